// File: doc/BRIEF.md
# Switching-Cycle Oscillator with External Clock Lock

This block produces the strobe that opens every switching cycle of a boost power-factor controller. Each strobe marks the start of the gate-off interval. A free-running counter sets the cycle length by default, and the period comes in as a count of system clocks on an input bus. The bus is wide enough to span roughly 21 kHz to 250 kHz at the system clock, and the nominal setting is 65 kHz.

A comparator outside the block decides whether synchronisation is allowed, and reports the result on `sync_en`. While `sync_en` is high, the block counts rising edges of `ext_clk`, which it first brings into the system clock domain. Once six edges have been seen, the block moves to the external source at the next internal cycle boundary. After that, every external rising edge starts one cycle, so the switching rate follows the external rate 1:1. The intended external range is 50 to 150 kHz, with a high time of 10 to 70 percent.

The external source is dropped in two cases: `sync_en` falls, or no external edge arrives for a programmable number of system clocks (about 108 µs). In either case the edge count is cleared. The internal counter then resumes from the last cycle start, so the cycle that follows is never shorter than the internal period.

Top module: `pfc_cycle_osc`

## Requirements
- R1: After reset, `cycle_start` and `locked` are both 0.
- R2: While `locked` is 0, `cycle_start` is a single-clock pulse that repeats every P clocks, where P is the value on `period_cycles`.
- R3: `locked` stays 0 until LOCK_PULSES (6) external rising edges have been counted while `sync_en` was high. After that, `locked` rises on the same clock as the next internal `cycle_start` pulse.
- R4: While `locked` is 1, every rising edge of `ext_clk` produces exactly one `cycle_start` pulse, 4 clocks after the edge is first driven. No internal pulses occur in this state.
- R5: While locked, if no external rising edge is detected for TIMEOUT_CYCLES clocks, `locked` falls. The edge count is cleared, so six new edges are needed before the block locks again.
- R6: If `sync_en` is 0 while locked, `locked` is 0 on the next clock, and the edge count is cleared.
- R7: After lock is lost, the next `cycle_start` comes no sooner than P clocks after the previous one. It comes on the next clock if that much time has already passed.
- R8: A `period_cycles` value below MIN_PERIOD (8) is treated as MIN_PERIOD.
- R9: External edges that arrive while `sync_en` is 0 are not counted towards lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_en | input | 1 | Comparator flag: pin level is above the synchronisation threshold |
| ext_clk | input | 1 | External synchronisation clock, asynchronous |
| period_cycles | input | PERIOD_W | Internal cycle period in system clocks |
| cycle_start | output | 1 | One-clock strobe that begins a switching cycle |
| locked | output | 1 | 1 while cycles follow the external clock |

## Verification
An external edge passes through two synchroniser flops and a registered edge detector, and the strobe is registered after that. A `cycle_start` caused by an edge therefore appears 4 clocks after the bench drives `ext_clk` high. An internal strobe appears one clock after the counter reaches P-1. `locked` changes on the same clock as the strobe that completes a lock. It falls one clock after `sync_en` drops, or one clock after the timeout count runs out. The bench drives all inputs on falling edges and steps a behavioural model on each rising edge. It compares both outputs at the next falling edge, and in addition measures strobe spacing and edge-to-strobe latency against these figures.

// File: rtl/pfc_osc_pkg.sv
package pfc_osc_pkg;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } osc_src_e;

    typedef struct packed {
        logic     start;
        osc_src_e src;
    } osc_step_t;

    function automatic logic [31:0] clog2_plus1(input int unsigned v);
        return 32'($clog2(v + 1));
    endfunction

endpackage

// File: rtl/pfc_osc_edge.sv
module pfc_osc_edge (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    output logic rise
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            rise <= 1'b0;
        end else begin
            sh   <= {sh[1:0], ext_in};
            rise <= sh[1] & ~sh[2];
        end
    end
endmodule

// File: rtl/pfc_osc_lock_track.sv
module pfc_osc_lock_track #(
    parameter int unsigned LOCK_PULSES    = 6,
    parameter int unsigned TIMEOUT_CYCLES = 27000
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_en,
    input  logic rise,
    output logic qualified,
    output logic expire
);
    localparam int unsigned LOCK_W = $clog2(LOCK_PULSES + 1);
    localparam int unsigned TMO_W  = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [LOCK_W-1:0] LOCK_MAX = LOCK_W'(LOCK_PULSES);
    localparam logic [TMO_W-1:0]  TMO_LAST = TMO_W'(TIMEOUT_CYCLES - 1);

    logic [LOCK_W-1:0] edges_q;
    logic [TMO_W-1:0]  quiet_q;

    assign expire    = !rise && (quiet_q == TMO_LAST);
    assign qualified = sync_en && (edges_q == LOCK_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
        end else if (rise || expire) begin
            quiet_q <= '0;
        end else begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !sync_en || expire) begin
            edges_q <= '0;
        end else if (rise && edges_q != LOCK_MAX) begin
            edges_q <= edges_q + 1'b1;
        end
    end
endmodule

// File: rtl/pfc_osc_period_timer.sv
module pfc_osc_period_timer #(
    parameter int unsigned PERIOD_W   = 16,
    parameter int unsigned MIN_PERIOD = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic [PERIOD_W-1:0] period_cycles,
    output logic                wrap
);
    localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_PERIOD);

    logic [PERIOD_W-1:0] count_q;
    logic [PERIOD_W-1:0] eff_period;

    always_comb begin
        eff_period = (period_cycles < MIN_P) ? MIN_P : period_cycles;
        wrap       = (count_q >= eff_period - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count_q <= '0;
        end else if (count_q != '1) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/pfc_cycle_osc.sv
module pfc_cycle_osc
    import pfc_osc_pkg::*;
#(
    parameter int unsigned PERIOD_W       = 16,
    parameter int unsigned MIN_PERIOD     = 8,
    parameter int unsigned LOCK_PULSES    = 6,
    parameter int unsigned TIMEOUT_CYCLES = 27000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sync_en,
    input  logic                ext_clk,
    input  logic [PERIOD_W-1:0] period_cycles,
    output logic                cycle_start,
    output logic                locked
);
    logic      ext_rise;
    logic      qualified;
    logic      expire;
    logic      int_wrap;
    osc_step_t step_d;
    osc_src_e  src_q;

    pfc_osc_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .ext_in (ext_clk),
        .rise   (ext_rise)
    );

    pfc_osc_lock_track #(
        .LOCK_PULSES    (LOCK_PULSES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .sync_en   (sync_en),
        .rise      (ext_rise),
        .qualified (qualified),
        .expire    (expire)
    );

    pfc_osc_period_timer #(
        .PERIOD_W   (PERIOD_W),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_timer (
        .clk           (clk),
        .rst           (rst),
        .restart       (step_d.start),
        .period_cycles (period_cycles),
        .wrap          (int_wrap)
    );

    always_comb begin
        step_d = '{start: 1'b0, src: src_q};
        case (src_q)
            SRC_INTERNAL: begin
                step_d.start = int_wrap;
                if (int_wrap && qualified && !expire) begin
                    step_d.src = SRC_EXTERNAL;
                end
            end
            default: begin
                step_d.start = ext_rise && sync_en;
                if (!sync_en || expire) begin
                    step_d.src = SRC_INTERNAL;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle_start <= 1'b0;
            src_q       <= SRC_INTERNAL;
        end else begin
            cycle_start <= step_d.start;
            src_q       <= step_d.src;
        end
    end

    assign locked = (src_q == SRC_EXTERNAL);
endmodule

// File: rtl/pfc_cycle_osc_chk.sv
module pfc_cycle_osc_chk #(
    parameter int unsigned TIMEOUT_CYCLES = 27000
) (
    input logic clk,
    input logic rst,
    input logic sync_en,
    input logic ext_rise,
    input logic cycle_start,
    input logic locked
);
    int unsigned silent;

    always_ff @(posedge clk) begin
        if (rst || ext_rise) begin
            silent <= 0;
        end else if (silent < TIMEOUT_CYCLES + 4) begin
            silent <= silent + 1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!cycle_start && !locked));

    p_lock_on_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> cycle_start);

    p_edge_starts_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && ext_rise && sync_en) |=> cycle_start);

    p_no_internal_when_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked) && cycle_start) |-> $past(ext_rise));

    p_timeout_unlocks_r5: assert property (@(posedge clk) disable iff (rst)
        (silent > TIMEOUT_CYCLES + 1) |-> !locked);

    p_sync_drop_unlocks_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && !sync_en) |=> !locked);

    p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);
endmodule

bind pfc_cycle_osc pfc_cycle_osc_chk #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_en     (sync_en),
    .ext_rise    (ext_rise),
    .cycle_start (cycle_start),
    .locked      (locked)
);

// File: tb/tb_pfc_cycle_osc.sv
module tb_pfc_cycle_osc;
    localparam int PW   = 16;
    localparam int MINP = 8;
    localparam int LOCK = 6;
    localparam int TMO  = 600;
    localparam int PER  = 300;
    localparam int EXTP = 250;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_en = 1'b0;
    logic          ext_clk = 1'b0;
    logic [PW-1:0] period_cycles = PW'(PER);
    logic          cycle_start;
    logic          locked;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag = "R1";

    int last_start = -1;
    int last_interval = 0;
    int last_rise = -100000;
    bit prev_locked = 1'b0;

    // reference model state
    int m_s1, m_s2, m_s3, m_rise, m_edges, m_quiet, m_cnt;
    bit m_locked, m_start;

    always #2 clk = ~clk;

    pfc_cycle_osc #(
        .PERIOD_W (PW), .MIN_PERIOD (MINP),
        .LOCK_PULSES (LOCK), .TIMEOUT_CYCLES (TMO)
    ) dut (
        .clk (clk), .rst (rst), .sync_en (sync_en), .ext_clk (ext_clk),
        .period_cycles (period_cycles),
        .cycle_start (cycle_start), .locked (locked)
    );

    always @(posedge clk) begin
        int per_eff;
        bit r, exp_now, lost, qual, wrap, sn, ln;
        cyc++;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rise = 0; m_edges = 0;
            m_quiet = 0; m_cnt = 0; m_locked = 0; m_start = 0;
        end else begin
            per_eff = (int'(period_cycles) < MINP) ? MINP : int'(period_cycles);
            r       = (m_rise != 0);
            exp_now = !r && (m_quiet == TMO - 1);
            lost    = !sync_en || exp_now;
            qual    = sync_en && (m_edges == LOCK);
            wrap    = (m_cnt >= per_eff - 1);
            sn      = m_locked ? (r && sync_en) : wrap;
            ln      = m_locked ? !lost : (wrap && qual && !exp_now);
            if (!sync_en || exp_now) m_edges = 0;
            else if (r && m_edges < LOCK) m_edges++;
            m_quiet = (r || exp_now) ? 0 : m_quiet + 1;
            if (sn) m_cnt = 0; else if (m_cnt < 65535) m_cnt++;
            m_start  = sn;
            m_locked = ln;
            m_rise = (m_s2 != 0 && m_s3 == 0) ? 1 : 0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk ? 1 : 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp_v, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(cycle_start == m_start, {tag, " cycle_start"}, cycle_start, m_start);
            check(locked == m_locked, {tag, " locked"}, locked, m_locked);
            if (cycle_start) begin
                if (last_start >= 0) last_interval = cyc - last_start;
                last_start = cyc;
                if (locked && prev_locked)
                    check(cyc - last_rise == 4, "R4 edge latency", cyc - last_rise, 4);
            end
            prev_locked = locked;
        end
    end

    task automatic ext_pulses(input int n, input int per, input int hi);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1;
            last_rise = cyc;
            repeat (hi) @(negedge clk);
            ext_clk = 1'b0;
            repeat (per - hi) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check(cycle_start == 1'b0, "R1 start after reset", cycle_start, 0);
        check(locked == 1'b0, "R1 locked after reset", locked, 0);
        rst = 1'b0;

        tag = "R2";
        repeat (1000) @(negedge clk);
        check(last_interval == PER, "R2 internal spacing", last_interval, PER);

        tag = "R9";
        ext_pulses(8, EXTP, 100);
        check(locked == 1'b0, "R9 edges ignored while disabled", locked, 0);

        tag = "R3";
        sync_en = 1'b1;
        ext_pulses(5, EXTP, 100);
        check(locked == 1'b0, "R3 five edges not enough", locked, 0);
        ext_pulses(1, EXTP, 30);
        tag = "R4";
        ext_pulses(4, EXTP, 170);
        check(locked == 1'b1, "R3 locked after six edges", locked, 1);
        check(last_interval == EXTP, "R4 follows external period", last_interval, EXTP);

        tag = "R5";
        repeat (TMO + 20) @(negedge clk);
        check(locked == 1'b0, "R5 timeout unlocks", locked, 0);
        check(last_interval >= PER, "R7 no short cycle after timeout", last_interval, PER);
        ext_pulses(3, EXTP, 100);
        check(locked == 1'b0, "R5 count cleared by timeout", locked, 0);
        ext_pulses(5, EXTP, 100);
        check(locked == 1'b1, "R5 relock after fresh edges", locked, 1);

        tag = "R6";
        ext_clk = 1'b1;
        last_rise = cyc;
        repeat (20) @(negedge clk);
        sync_en = 1'b0;
        @(negedge clk);
        check(locked == 1'b0, "R6 sync drop unlocks", locked, 0);
        ext_clk = 1'b0;
        repeat (PER + 20) @(negedge clk);
        check(last_interval >= PER, "R7 no short cycle after drop", last_interval, PER);
        sync_en = 1'b1;
        ext_pulses(5, EXTP, 100);
        check(locked == 1'b0, "R6 count cleared by drop", locked, 0);
        sync_en = 1'b0;

        tag = "R8";
        period_cycles = PW'(3);
        repeat (100) @(negedge clk);
        check(last_interval == MINP, "R8 period clamped", last_interval, MINP);
        period_cycles = PW'(20);
        repeat (100) @(negedge clk);
        check(last_interval == 20, "R2 short programmed period", last_interval, 20);

        finish_run();
    end
endmodule